// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This unit decides how an issuing load obtains its data when older stores may still sit in the store queue. When a load is accepted, the unit captures its byte address, access size, sequence number, load-queue slot and the store-queue position noted when it was dispatched. From that position it walks toward older store entries, one entry per clock, and stops when it arrives at the writeback pointer. The first relevant store it meets settles the outcome.

There are three normal outcomes. A store that covers every byte of the load supplies the data, shifted into place. A store that covers only some of the load's bytes and has not yet been written back makes the load replay; the unit also keeps a record of the stall for the oldest load that has hit this case. If no store is relevant, the load is sent to the data cache. A blocked cache leaves a sticky flag that clears when it is read. An uncacheable load that is not both at the head of the load queue and ready to commit is turned away with a machine-check fault pulse, and no walk takes place.

The store queue is read through a combinational read port: the unit drives an index and the entry fields come back in the same cycle. The writeback pointer must hold steady while a walk is in progress.

Top module: `stld_fwd_search`

## Requirements
- R1: After a load is accepted, the walk starts at its captured store index. In each search cycle the unit ends the walk if the current index equals `wb_ptr`. Otherwise it reads the entry one position older, wrapping from 0 to SQ_DEPTH-1, and that entry becomes the current index. Each outcome pulse appears in the cycle after the search cycle that decided it. With the default depth of 8, a load captured at index 2 with `wb_ptr` = 6 reads entries 1, 0, 7 and 6.
- R2: An entry whose size field is 0 has no data yet. The walk passes over it as if it were absent.
- R3: An entry with address S and size Z fully covers a load with address A and size L when A >= S and A+L <= S+Z. In that case `fwd_data` equals the entry data shifted right by 8*(A & (Z-1)) bits. Sizes are byte counts of 1, 2, 4 or 8.
- R4: When the store read in search cycle j (counting from 0) fully covers the load, `fwd_valid` pulses for exactly one cycle, j+1 cycles after the search begins. The latency from the covering store to the forwarded data is therefore one cycle.
- R5: The first entry that decides the outcome is the youngest older store. Entries older than it have no effect on the result.
- R6: A partial overlap means some bytes of the load fall inside the store's byte range but coverage is not full. If such a store has its done flag set, the walk passes over it.
- R7: A partial overlap with a store whose done flag is clear makes `replay_valid` pulse and sets `stall_active`.
- R8: On each replay, the stall record (`stall_store_seq`, `stall_load_idx`) is loaded only if no stall is active or the replaying load's sequence number is smaller than that of the recorded load. `stall_release` clears `stall_active`; a new record taken in the same cycle wins.
- R9: When the walk reaches `wb_ptr` without a decision, `cache_req` pulses for one cycle with the load's address and size on `cache_addr` and `cache_size`.
- R10: If `cache_blocked` is high during a `cache_req` pulse, `ld_blocked` rises on the next cycle and holds. A pulse on `ld_blocked_rd` clears it one cycle later.
- R11: An accepted load with `ld_uncache` high that is not both at the head and ready to commit raises `fault_valid` for one cycle, in the cycle after acceptance, and starts no walk. An uncacheable load that meets both conditions is walked normally.
- R12: Each accepted load produces exactly one single-cycle outcome pulse. A load presented while `busy` is high is ignored.
- R13: After reset all outcome pulses are low, and `busy`, `stall_active` and `ld_blocked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load request; accepted when not busy |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 4 | Load size in bytes (1, 2, 4, 8) |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_lq_idx | input | LQ_IW | Load-queue slot of the load |
| ld_sq_idx | input | SQ_IW | Store index captured at dispatch |
| ld_uncache | input | 1 | Load targets uncacheable space |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_commit_rdy | input | 1 | Load is ready to commit |
| wb_ptr | input | SQ_IW | Store-queue writeback pointer |
| busy | output | 1 | Walk in progress |
| sq_rd_idx | output | SQ_IW | Store-queue read index |
| sq_rd_addr | input | ADDR_W | Entry store address |
| sq_rd_size | input | 4 | Entry size, 0 if data not yet present |
| sq_rd_data | input | DATA_W | Entry store data |
| sq_rd_seq | input | SEQ_W | Entry sequence number |
| sq_rd_done | input | 1 | Entry already written back |
| fwd_valid | output | 1 | Forwarded data valid pulse |
| fwd_data | output | DATA_W | Forwarded data |
| replay_valid | output | 1 | Load must be rescheduled |
| stall_active | output | 1 | Partial-forward stall in force |
| stall_store_seq | output | SEQ_W | Sequence number of the blocking store |
| stall_load_idx | output | LQ_IW | Load-queue slot of the stalled load |
| stall_release | input | 1 | Blocking store has written back |
| cache_req | output | 1 | Cache access pulse |
| cache_addr | output | ADDR_W | Cache access address |
| cache_size | output | 4 | Cache access size |
| cache_blocked | input | 1 | Cache cannot accept the access |
| ld_blocked | output | 1 | Sticky load-blocked flag |
| ld_blocked_rd | input | 1 | Read strobe that clears ld_blocked |
| fault_valid | output | 1 | Machine-check fault pulse |

## Verification
A replay decision and a stall release can land in the same cycle. The bench provokes this by pulsing `stall_release` in the very cycle the stall record is being loaded, and then requires `stall_active` to stay set with the new record. The sticky blocked flag can likewise be set and read in the same cycle. The bench holds `cache_blocked` high during a cache pulse and strobes the read at that moment; set must win, and a later read alone must then clear the flag.

// File: rtl/stld_pkg.sv
// Package: shared types for the store-to-load forwarding search unit.
// Assumes nothing beyond the parameters of the top module.
package stld_pkg;
    // Walk controller state
    typedef enum logic {
        WALK_IDLE   = 1'b0,
        WALK_SEARCH = 1'b1
    } walk_state_e;
endpackage

// File: rtl/stld_overlap_cls.sv
// Module: stld_overlap_cls
// Classifies one store entry against the captured load: full cover, blocking
// partial overlap, or irrelevant. Also aligns the store data for forwarding.
// Assumes byte addresses, sizes of 1/2/4/8 bytes and DATA_W of 64.
module stld_overlap_cls #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [3:0]        ld_size,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [3:0]        st_size,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_done,
    output logic              full_hit,
    output logic              part_block,
    output logic [DATA_W-1:0] aligned_data
);
    localparam int SH_W = $clog2(DATA_W);

    logic [ADDR_W:0] ld_lo, ld_hi, st_lo, st_hi;
    logic            has_data, covers, touches;
    logic [2:0]      off_mask, byte_off;
    logic [SH_W-1:0] shift_amt;

    // Byte ranges of load and store, one bit wider to hold the carry
    always_comb begin
        ld_lo = {1'b0, ld_addr};
        st_lo = {1'b0, st_addr};
        ld_hi = ld_lo + {{(ADDR_W-3){1'b0}}, ld_size};
        st_hi = st_lo + {{(ADDR_W-3){1'b0}}, st_size};
    end

    // Coverage and overlap decision
    always_comb begin
        has_data   = (st_size != 4'd0);
        covers     = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        touches    = (ld_lo < st_hi) && (ld_hi > st_lo);
        full_hit   = has_data && covers;
        part_block = has_data && touches && !covers && !st_done;
    end

    // Data alignment: shift by the load's byte offset inside the store
    always_comb begin
        off_mask     = st_size[2:0] - 3'd1;
        byte_off     = ld_addr[2:0] & off_mask;
        shift_amt    = SH_W'({byte_off, 3'b000});
        aligned_data = st_data >> shift_amt;
    end
endmodule

// File: rtl/stld_stall_track.sv
// Module: stld_stall_track
// Holds the partial-forward stall record (oldest stalled load wins) and the
// sticky cache-blocked flag. A new record beats a release in the same cycle;
// a new block event beats a read strobe in the same cycle.
module stld_stall_track #(
    parameter int SEQ_W = 8,
    parameter int LQ_IW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic [SEQ_W-1:0] rec_st_seq,
    input  logic [SEQ_W-1:0] rec_ld_seq,
    input  logic [LQ_IW-1:0] rec_ld_idx,
    input  logic             release_i,
    input  logic             cache_go,
    input  logic             cache_blocked,
    input  logic             blk_rd,
    output logic             stall_active,
    output logic [SEQ_W-1:0] stall_st_seq,
    output logic [LQ_IW-1:0] stall_ld_idx,
    output logic             blocked
);
    logic [SEQ_W-1:0] stall_ld_seq;
    logic             take;

    // Decide whether the replaying load replaces the current record
    always_comb take = rec_en && (!stall_active || (rec_ld_seq < stall_ld_seq));

    // Stall record register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_active <= 1'b0;
            stall_st_seq <= '0;
            stall_ld_seq <= '0;
            stall_ld_idx <= '0;
        end else if (take) begin
            stall_active <= 1'b1;
            stall_st_seq <= rec_st_seq;
            stall_ld_seq <= rec_ld_seq;
            stall_ld_idx <= rec_ld_idx;
        end else if (release_i) begin
            stall_active <= 1'b0;
        end
    end

    // Sticky blocked flag, cleared by a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) blocked <= 1'b0;
        else if (cache_go && cache_blocked) blocked <= 1'b1;
        else if (blk_rd) blocked <= 1'b0;
    end

    p_blocked_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked) |-> $past(cache_go && cache_blocked));

    p_stall_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_active) |-> $past(release_i));
endmodule

// File: rtl/stld_fwd_search.sv
// Module: stld_fwd_search (top)
// Accepts one load at a time, walks the store queue toward older entries one
// entry per cycle until the writeback pointer, and emits exactly one outcome:
// forward, replay, cache access or machine-check fault. Assumes a store-queue
// read port with same-cycle data and a writeback pointer stable during a walk.
module stld_fwd_search
    import stld_pkg::*;
#(
    parameter int SQ_DEPTH = 8,
    parameter int LQ_DEPTH = 8,
    parameter int ADDR_W   = 16,
    parameter int SEQ_W    = 8,
    parameter int DATA_W   = 64,
    localparam int SQ_IW   = $clog2(SQ_DEPTH),
    localparam int LQ_IW   = $clog2(LQ_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [3:0]        ld_size,
    input  logic [SEQ_W-1:0]  ld_seq,
    input  logic [LQ_IW-1:0]  ld_lq_idx,
    input  logic [SQ_IW-1:0]  ld_sq_idx,
    input  logic              ld_uncache,
    input  logic              ld_at_head,
    input  logic              ld_commit_rdy,
    input  logic [SQ_IW-1:0]  wb_ptr,
    output logic              busy,
    output logic [SQ_IW-1:0]  sq_rd_idx,
    input  logic [ADDR_W-1:0] sq_rd_addr,
    input  logic [3:0]        sq_rd_size,
    input  logic [DATA_W-1:0] sq_rd_data,
    input  logic [SEQ_W-1:0]  sq_rd_seq,
    input  logic              sq_rd_done,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              replay_valid,
    output logic              stall_active,
    output logic [SEQ_W-1:0]  stall_store_seq,
    output logic [LQ_IW-1:0]  stall_load_idx,
    input  logic              stall_release,
    output logic              cache_req,
    output logic [ADDR_W-1:0] cache_addr,
    output logic [3:0]        cache_size,
    input  logic              cache_blocked,
    output logic              ld_blocked,
    input  logic              ld_blocked_rd,
    output logic              fault_valid
);
    localparam logic [SQ_IW-1:0] SQ_LAST = SQ_IW'(SQ_DEPTH - 1);

    walk_state_e       state;
    logic [SQ_IW-1:0]  cur_idx, probe_idx;
    logic [ADDR_W-1:0] q_addr;
    logic [3:0]        q_size;
    logic [SEQ_W-1:0]  q_seq;
    logic [LQ_IW-1:0]  q_lq;
    logic              at_end, full_hit, part_block, stall_rec;
    logic [DATA_W-1:0] aligned;
    logic              mc_reject;

    // Next-older store index with wrap
    always_comb probe_idx = (cur_idx == '0) ? SQ_LAST : cur_idx - 1'b1;

    // Walk status and read-port drive
    always_comb begin
        busy      = (state == WALK_SEARCH);
        at_end    = (cur_idx == wb_ptr);
        sq_rd_idx = probe_idx;
        stall_rec = busy && !at_end && !full_hit && part_block;
        mc_reject = ld_uncache && !(ld_at_head && ld_commit_rdy);
    end

    stld_overlap_cls #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cls (
        .ld_addr      (q_addr),
        .ld_size      (q_size),
        .st_addr      (sq_rd_addr),
        .st_size      (sq_rd_size),
        .st_data      (sq_rd_data),
        .st_done      (sq_rd_done),
        .full_hit     (full_hit),
        .part_block   (part_block),
        .aligned_data (aligned)
    );

    stld_stall_track #(.SEQ_W(SEQ_W), .LQ_IW(LQ_IW)) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .rec_en        (stall_rec),
        .rec_st_seq    (sq_rd_seq),
        .rec_ld_seq    (q_seq),
        .rec_ld_idx    (q_lq),
        .release_i     (stall_release),
        .cache_go      (cache_req),
        .cache_blocked (cache_blocked),
        .blk_rd        (ld_blocked_rd),
        .stall_active  (stall_active),
        .stall_st_seq  (stall_store_seq),
        .stall_ld_idx  (stall_load_idx),
        .blocked       (ld_blocked)
    );

    // Walk controller and registered outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= WALK_IDLE;
            cur_idx      <= '0;
            q_addr       <= '0;
            q_size       <= '0;
            q_seq        <= '0;
            q_lq         <= '0;
            fwd_valid    <= 1'b0;
            fwd_data     <= '0;
            replay_valid <= 1'b0;
            cache_req    <= 1'b0;
            cache_addr   <= '0;
            cache_size   <= '0;
            fault_valid  <= 1'b0;
        end else begin
            fwd_valid    <= 1'b0;
            replay_valid <= 1'b0;
            cache_req    <= 1'b0;
            fault_valid  <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (ld_valid) begin
                        q_addr  <= ld_addr;
                        q_size  <= ld_size;
                        q_seq   <= ld_seq;
                        q_lq    <= ld_lq_idx;
                        cur_idx <= ld_sq_idx;
                        if (mc_reject) fault_valid <= 1'b1;
                        else           state       <= WALK_SEARCH;
                    end
                end
                WALK_SEARCH: begin
                    if (at_end) begin
                        cache_req  <= 1'b1;
                        cache_addr <= q_addr;
                        cache_size <= q_size;
                        state      <= WALK_IDLE;
                    end else if (full_hit) begin
                        fwd_valid <= 1'b1;
                        fwd_data  <= aligned;
                        state     <= WALK_IDLE;
                    end else if (part_block) begin
                        replay_valid <= 1'b1;
                        state        <= WALK_IDLE;
                    end else begin
                        cur_idx <= probe_idx;
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    p_single_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, replay_valid, cache_req, fault_valid}));

    p_fault_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(ld_valid && ld_uncache && !(ld_at_head && ld_commit_rdy)));

    p_record_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stall_store_seq) |-> replay_valid);

    p_fwd_after_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(busy));

    p_no_walk_on_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !busy);
endmodule

// File: tb/sim_stld_fwd_search.sv
module sim_stld_fwd_search;
    localparam int CLK_PERIOD = 10;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 0;
    logic [15:0] ld_addr = 0;
    logic [3:0]  ld_size = 0;
    logic [7:0]  ld_seq = 0;
    logic [2:0]  ld_lq_idx = 0;
    logic [2:0]  ld_sq_idx = 0;
    logic        ld_uncache = 0, ld_at_head = 0, ld_commit_rdy = 0;
    logic [2:0]  wb_ptr = 0;
    logic        busy;
    logic [2:0]  sq_rd_idx;
    logic [15:0] sq_rd_addr;
    logic [3:0]  sq_rd_size;
    logic [63:0] sq_rd_data;
    logic [7:0]  sq_rd_seq;
    logic        sq_rd_done;
    logic        fwd_valid, replay_valid, stall_active, cache_req, ld_blocked, fault_valid;
    logic [63:0] fwd_data;
    logic [7:0]  stall_store_seq;
    logic [2:0]  stall_load_idx;
    logic        stall_release = 0;
    logic [15:0] cache_addr;
    logic [3:0]  cache_size;
    logic        cache_blocked = 0;
    logic        ld_blocked_rd = 0;

    logic [15:0] m_addr [D];
    logic [3:0]  m_size [D];
    logic [63:0] m_data [D];
    logic [7:0]  m_seq  [D];
    logic        m_done [D];

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Store-queue model answering the read port in the same cycle
    always_comb begin
        sq_rd_addr = m_addr[sq_rd_idx];
        sq_rd_size = m_size[sq_rd_idx];
        sq_rd_data = m_data[sq_rd_idx];
        sq_rd_seq  = m_seq[sq_rd_idx];
        sq_rd_done = m_done[sq_rd_idx];
    end

    stld_fwd_search u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_sq();
        for (int i = 0; i < D; i++) begin
            m_addr[i] = 16'hF000 + 16'(i * 16);
            m_size[i] = 4'd0; m_data[i] = '0; m_seq[i] = 8'(i); m_done[i] = 1'b0;
        end
    endtask

    task automatic put(input int i, input int a, input int z, input logic [63:0] dt,
                       input int sq, input bit dn);
        m_addr[i] = 16'(a); m_size[i] = 4'(z); m_data[i] = dt; m_seq[i] = 8'(sq); m_done[i] = dn;
    endtask

    // Expected outcome from the requirements: 0 fwd, 1 replay, 2 cache
    task automatic model(input int a, input int l, input int sidx,
                         output int kind, output int lat, output logic [63:0] dat);
        int cur = sidx;
        kind = 2; lat = 0; dat = '0;
        for (int j = 0; j <= D; j++) begin
            int p;
            if (cur == int'(wb_ptr)) begin kind = 2; lat = j + 2; return; end
            p = (cur + D - 1) % D;
            if (m_size[p] != 0) begin
                int s = int'(m_addr[p]); int z = int'(m_size[p]);
                bit full = (a >= s) && (a + l <= s + z);
                bit ovl  = (a < s + z) && (a + l > s);
                if (full) begin
                    kind = 0; lat = j + 2;
                    dat = m_data[p] >> (8 * (a & (z - 1))); return;
                end
                if (ovl && !m_done[p]) begin kind = 1; lat = j + 2; return; end
            end
            cur = p;
        end
    endtask

    // Present a load, measure the outcome and its latency, compare with model
    task automatic run_load(input int a, input int l, input int sq, input int lq, input int sidx,
                            input bit unc, input bit hd, input bit rdy, input bit exp_fault,
                            input string tag);
        int kind, lat, got, glat;
        logic [63:0] dat;
        model(a, l, sidx, kind, lat, dat);
        if (exp_fault) begin kind = 3; lat = 1; end
        @(negedge clk);
        ld_valid = 1; ld_addr = 16'(a); ld_size = 4'(l); ld_seq = 8'(sq);
        ld_lq_idx = 3'(lq); ld_sq_idx = 3'(sidx);
        ld_uncache = unc; ld_at_head = hd; ld_commit_rdy = rdy;
        @(negedge clk);
        ld_valid = 0; got = -1; glat = 0;
        for (int c = 1; c < 30; c++) begin
            if (fwd_valid) got = 0; else if (replay_valid) got = 1;
            else if (cache_req) got = 2; else if (fault_valid) got = 3;
            if (got >= 0) begin glat = c; break; end
            @(negedge clk);
        end
        chk(got == kind, {tag, " outcome"}, 64'(got), 64'(kind));
        chk(glat == lat, {tag, " latency"}, 64'(glat), 64'(lat));
        if (kind == 0) chk(fwd_data == dat, {tag, " data"}, fwd_data, dat);
        if (kind == 2) chk(cache_addr == 16'(a) && cache_size == 4'(l), {tag, " cache addr"},
                           64'(cache_addr), 64'(a));
    endtask

    task automatic t_reset();
        chk(!fwd_valid && !replay_valid && !cache_req && !fault_valid, "R13 pulses", 0, 0);
        chk(!busy && !stall_active && !ld_blocked, "R13 state",
            64'({busy, stall_active, ld_blocked}), 0);
    endtask

    task automatic t_full_forward();
        clear_sq(); wb_ptr = 0;
        put(5, 'h100, 8, 64'h8877665544332211, 20, 0);
        run_load('h103, 1, 30, 1, 6, 0, 0, 0, 0, "R3 R4 byte at offset 3");
        run_load('h106, 2, 31, 1, 6, 0, 0, 0, 0, "R3 half at offset 6");
        put(5, 'h104, 4, 64'h00000000DDCCBBAA, 20, 0);
        run_load('h104, 4, 32, 1, 6, 0, 0, 0, 0, "R3 exact word");
    endtask

    task automatic t_youngest();
        clear_sq(); wb_ptr = 0;
        put(5, 'h200, 4, 64'h11112222, 21, 0);
        put(4, 'h200, 8, 64'h9999888877776666, 20, 0);
        run_load('h200, 4, 40, 2, 6, 0, 0, 0, 0, "R5 youngest wins");
    endtask

    task automatic t_skip_empty();
        clear_sq(); wb_ptr = 0;
        put(5, 'h300, 0, 64'hDEAD, 21, 0);
        put(4, 'h300, 4, 64'hCAFEF00D, 20, 0);
        run_load('h300, 4, 41, 2, 6, 0, 0, 0, 0, "R2 size zero skipped");
    endtask

    task automatic t_done_transparent();
        clear_sq(); wb_ptr = 0;
        put(5, 'h400, 4, 64'h1, 21, 1);
        put(4, 'h400, 8, 64'h0807060504030201, 20, 0);
        run_load('h402, 4, 42, 2, 6, 0, 0, 0, 0, "R6 completed partial passed");
    endtask

    task automatic t_stall_record();
        clear_sq(); wb_ptr = 0;
        put(5, 'h500, 2, 64'h1, 77, 0);
        run_load('h500, 4, 40, 3, 6, 0, 0, 0, 0, "R7 partial replay");
        chk(stall_active, "R7 stall set", 64'(stall_active), 1);
        chk(stall_store_seq == 77 && stall_load_idx == 3, "R8 first record",
            64'(stall_store_seq), 77);
        put(5, 'h500, 2, 64'h1, 88, 0);
        run_load('h501, 2, 50, 5, 6, 0, 0, 0, 0, "R8 younger replay");
        chk(stall_store_seq == 77 && stall_load_idx == 3, "R8 younger keeps record",
            64'(stall_load_idx), 3);
        put(5, 'h500, 2, 64'h1, 99, 0);
        run_load('h4FF, 2, 30, 1, 6, 0, 0, 0, 0, "R8 older replay");
        chk(stall_store_seq == 99 && stall_load_idx == 1, "R8 older replaces",
            64'(stall_load_idx), 1);
        @(negedge clk); stall_release = 1;
        @(negedge clk); stall_release = 0;
        chk(!stall_active, "R8 release clears", 64'(stall_active), 0);
        // Release in the same cycle a new record is taken: record wins
        put(5, 'h500, 2, 64'h1, 55, 0);
        wb_ptr = 5;
        @(negedge clk);
        ld_valid = 1; ld_addr = 'h500; ld_size = 4; ld_seq = 60; ld_lq_idx = 6;
        ld_sq_idx = 6; ld_uncache = 0;
        @(negedge clk); ld_valid = 0; stall_release = 1;
        @(negedge clk); stall_release = 0;
        chk(replay_valid, "R8 replay with release", 64'(replay_valid), 1);
        chk(stall_active && stall_store_seq == 55 && stall_load_idx == 6,
            "R8 record beats release", 64'(stall_store_seq), 55);
        @(negedge clk); stall_release = 1;
        @(negedge clk); stall_release = 0;
    endtask

    task automatic t_walk_wrap();
        clear_sq(); wb_ptr = 6;
        put(1, 'h700, 8, 64'h1, 10, 0); put(0, 'h710, 8, 64'h2, 11, 0);
        put(7, 'h720, 8, 64'h3, 12, 0); put(6, 'h730, 8, 64'h4, 13, 0);
        put(5, 'h800, 8, 64'h5, 9, 0);
        run_load('h800, 8, 50, 0, 2, 0, 0, 0, 0, "R1 R9 wrap to cache");
        put(7, 'h800, 8, 64'hABCD0000, 12, 0);
        run_load('h802, 2, 51, 0, 2, 0, 0, 0, 0, "R1 wrap forward from entry 7");
        wb_ptr = 3;
        run_load('h900, 1, 52, 0, 3, 0, 0, 0, 0, "R1 start at wb pointer");
    endtask

    task automatic t_blocked();
        clear_sq(); wb_ptr = 2;
        @(negedge clk); cache_blocked = 1;
        run_load('hA00, 4, 60, 0, 2, 0, 0, 0, 0, "R9 blocked access");
        ld_blocked_rd = 1;
        @(negedge clk); ld_blocked_rd = 0; cache_blocked = 0;
        chk(ld_blocked, "R10 set beats read", 64'(ld_blocked), 1);
        @(negedge clk);
        chk(ld_blocked, "R10 sticky", 64'(ld_blocked), 1);
        ld_blocked_rd = 1;
        @(negedge clk); ld_blocked_rd = 0;
        chk(!ld_blocked, "R10 read clears", 64'(ld_blocked), 0);
    endtask

    task automatic t_fault();
        clear_sq(); wb_ptr = 1;
        run_load('hB00, 8, 70, 2, 3, 1, 0, 1, 1, "R11 not at head");
        run_load('hB00, 8, 71, 2, 3, 1, 1, 0, 1, "R11 not ready");
        run_load('hB00, 8, 72, 2, 3, 1, 1, 1, 0, "R11 allowed uncacheable walks");
    endtask

    task automatic t_busy_ignore();
        int outs = 0;
        clear_sq(); wb_ptr = 6;
        @(negedge clk);
        ld_valid = 1; ld_addr = 'hC00; ld_size = 4; ld_sq_idx = 2; ld_uncache = 0;
        @(negedge clk);
        chk(busy, "R12 busy during walk", 64'(busy), 1);
        ld_uncache = 1; ld_at_head = 0; ld_addr = 'hD00;
        @(negedge clk); ld_valid = 0; ld_uncache = 0;
        for (int c = 0; c < 12; c++) begin
            if (fault_valid) chk(0, "R12 busy load ignored", 1, 0);
            if (cache_req) begin
                outs++;
                chk(cache_addr == 'hC00, "R12 first load served", 64'(cache_addr), 'hC00);
            end
            @(negedge clk);
        end
        chk(outs == 1, "R12 one outcome", 64'(outs), 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_sq();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_full_forward();
        t_youngest();
        t_skip_empty();
        t_done_transparent();
        t_stall_record();
        t_walk_wrap();
        t_blocked();
        t_fault();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule